// File: doc/BRIEF.md
# Video Sync Word Detector and Conditioner

This block sits on a 10-bit parallel video word path and runs on the parallel word clock. It samples each incoming word and inspects the eight upper bits, 9 down to 2. If they are all zeros or all ones, the word is one of the reserved timing-reference codes.

On a match, the block overwrites the two low bits with the value of the upper bits. As a result, a source that drives only eight meaningful bits and a full 10-bit source both give the same clean sync word downstream. Every word leaves the block registered, exactly one clock after it was sampled.

Each match also pulls an active-low detect flag low for a fixed three-word window. The window is run by a two-state machine:
- `ST_IDLE` holds the flag high.
- `ST_HOLD` holds it low while a counter runs out.
- The transitions are: IDLE to HOLD on a match; HOLD to HOLD (counter reloaded) on a new match; HOLD to HOLD (counter decremented) while the count is not zero; HOLD to IDLE when the count reaches zero; and any state to IDLE while bypass is high.

A bypass input stops both detection and forcing, so that arbitrary data passes through untouched.

Top module: `sync_word_conditioner`

## Requirements
- R1: After a clock edge with `rst` high, `sync_n` is 1 and `word_out` is 10'h000.
- R2: When `bypass` is low and `word_in[9:2]` is 8'h00 at an edge, `word_out` is 10'h000 after that edge. Bit 0 is the least significant bit.
- R3: When `bypass` is low and `word_in[9:2]` is 8'hFF at an edge, `word_out` is 10'h3FF after that edge.
- R4: When `bypass` is low and `word_in[9:2]` is neither 8'h00 nor 8'hFF, `word_out` after the edge equals `word_in` from that edge.
- R5: After a match at edge k, with no further match and no bypass, `sync_n` is 0 after edges k, k+1 and k+2, and 1 after edge k+3.
- R6: A match while `sync_n` is already low restarts the window, so `sync_n` stays low for three full cycles counted from the new match.
- R7: When `bypass` is high at an edge, `word_out` after that edge equals `word_in` unchanged, including reserved codes, and `sync_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bypass | input | 1 | Active high; disables detection and bit forcing |
| word_in | input | 10 | Parallel video word, bit 9 is the MSB |
| word_out | output | 10 | Conditioned word, one cycle of latency |
| sync_n | output | 1 | Sync detect flag, active low, three-word pulse |

## Verification
The assertions assume that `word_in`, `bypass` and `rst` are stable around each rising edge and change only between edges. They also assume that reset is synchronous, so the clocked properties can compare an output with the inputs sampled one edge earlier. The stimulus changes all inputs on the falling edge only. It mixes both reserved patterns with every low-bit combination, back-to-back matches that retrigger the pulse, bypass applied in the middle of a pulse, and a reset in the middle of a run, so the properties are exercised across all state transitions.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;

    typedef enum logic [1:0] {
        MATCH_NONE = 2'd0,
        MATCH_LOW  = 2'd1,
        MATCH_HIGH = 2'd2
    } match_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } pulse_state_e;

endpackage

// File: rtl/sync_code_classify.sv
module sync_code_classify
    import sync_cond_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic [TAG_W-1:0] tag_bits,
    input  logic             bypass,
    output match_e           kind
);

    localparam logic [TAG_W-1:0] ALL_LOW  = '0;
    localparam logic [TAG_W-1:0] ALL_HIGH = '1;

    always_comb begin
        kind = MATCH_NONE;
        if (!bypass) begin
            if (tag_bits == ALL_LOW) begin
                kind = MATCH_LOW;
            end else if (tag_bits == ALL_HIGH) begin
                kind = MATCH_HIGH;
            end
        end
    end

    always_comb begin
        assert_kind_gated_R7: assert (!(bypass && kind != MATCH_NONE))
            else $error("classifier reported a match while bypassed");
    end

endmodule

// File: rtl/sync_word_stage.sv
module sync_word_stage
    import sync_cond_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] word_i,
    input  match_e            kind_i,
    output logic [DATA_W-1:0] word_o
);

    localparam int TAG_W = DATA_W - LOW_W;

    logic [DATA_W-1:0] shaped;

    assign shaped[DATA_W-1:LOW_W] = word_i[DATA_W-1:LOW_W];

    for (genvar gi = 0; gi < LOW_W; gi++) begin : g_low
        always_comb begin
            unique case (kind_i)
                MATCH_LOW:  shaped[gi] = 1'b0;
                MATCH_HIGH: shaped[gi] = 1'b1;
                default:    shaped[gi] = word_i[gi];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
        end else begin
            word_o <= shaped;
        end
    end

    logic [TAG_W-1:0] unused_tag_chk;
    assign unused_tag_chk = shaped[DATA_W-1:LOW_W];

    assert_upper_kept_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> word_o[DATA_W-1:LOW_W] == $past(unused_tag_chk))
        else $error("upper bits altered by stage");

endmodule

// File: rtl/sync_pulse_fsm.sv
module sync_pulse_fsm
    import sync_cond_pkg::*;
#(
    parameter int PULSE_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    input  logic clear_i,
    output logic sync_n_o
);

    localparam int CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_LEN - 1);

    pulse_state_e     state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (clear_i) begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
        end else if (hit_i) begin
            state_nx = ST_HOLD;
            cnt_nx   = RELOAD;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt_nx = '0;
                end
                ST_HOLD: begin
                    if (cnt == '0) begin
                        state_nx = ST_IDLE;
                    end else begin
                        cnt_nx = cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE: sync_n_o = 1'b1;
            ST_HOLD: sync_n_o = 1'b0;
        endcase
    end

    assert_hit_pulls_low_R5: assert property (@(posedge clk) disable iff (rst)
        (hit_i && !clear_i) |=> !sync_n_o)
        else $error("detect flag not asserted after match");

    assert_window_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && cnt == '0 && !hit_i) |=> sync_n_o)
        else $error("detect flag outlived its window");

    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && hit_i && !clear_i) |=> (cnt == RELOAD))
        else $error("retrigger did not reload the window");

    assert_clear_idle_R7: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> sync_n_o)
        else $error("detect flag low after bypass");

endmodule

// File: rtl/sync_word_conditioner.sv
module sync_word_conditioner
    import sync_cond_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int LOW_W     = 2,
    parameter int PULSE_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] word_out,
    output logic              sync_n
);

    localparam int TAG_W = DATA_W - LOW_W;

    match_e kind;
    logic   hit;

    sync_code_classify #(.TAG_W(TAG_W)) u_classify (
        .tag_bits (word_in[DATA_W-1:LOW_W]),
        .bypass   (bypass),
        .kind     (kind)
    );

    assign hit = (kind != MATCH_NONE);

    sync_word_stage #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .word_i (word_in),
        .kind_i (kind),
        .word_o (word_out)
    );

    sync_pulse_fsm #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .hit_i    (hit),
        .clear_i  (bypass),
        .sync_n_o (sync_n)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (sync_n && word_out == '0))
        else $error("reset state wrong");

    assert_zero_force_R2: assert property (@(posedge clk) disable iff (rst)
        (!bypass && word_in[DATA_W-1:LOW_W] == '0) |=> word_out == '0)
        else $error("all-zero code not forced");

    assert_ones_force_R3: assert property (@(posedge clk) disable iff (rst)
        (!bypass && word_in[DATA_W-1:LOW_W] == '1) |=> word_out == '1)
        else $error("all-ones code not forced");

    assert_pass_through_R4: assert property (@(posedge clk) disable iff (rst)
        (bypass || (word_in[DATA_W-1:LOW_W] != '0 && word_in[DATA_W-1:LOW_W] != '1))
        |=> word_out == $past(word_in))
        else $error("ordinary word altered");

endmodule

// File: tb/sync_word_conditioner_bench.sv
module sync_word_conditioner_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bypass = 1'b0;
    logic [9:0] word_in = '0;
    logic [9:0] word_out;
    logic       sync_n;

    always #5 clk = ~clk;

    sync_word_conditioner u_sync_word_conditioner (
        .clk      (clk),
        .rst      (rst),
        .bypass   (bypass),
        .word_in  (word_in),
        .word_out (word_out),
        .sync_n   (sync_n)
    );

    int         errors = 0;
    int         checks = 0;
    int         exp_left = 0;
    logic [9:0] exp_word = '0;
    bit         done = 1'b0;

    task automatic step(input logic r, input logic b, input logic [9:0] w);
        string tag_w;
        string tag_s;
        logic  exp_sync;
        bit    active;
        @(negedge clk);
        rst = r;
        bypass = b;
        word_in = w;
        @(posedge clk);
        active = (exp_left > 0);
        if (r) begin
            exp_word = '0; exp_left = 0; tag_w = "R1"; tag_s = "R1";
        end else if (b) begin
            exp_word = w; exp_left = 0; tag_w = "R7"; tag_s = "R7";
        end else if (w[9:2] == 8'h00) begin
            exp_word = 10'h000; exp_left = 3; tag_w = "R2";
            tag_s = active ? "R6" : "R5";
        end else if (w[9:2] == 8'hFF) begin
            exp_word = 10'h3FF; exp_left = 3; tag_w = "R3";
            tag_s = active ? "R6" : "R5";
        end else begin
            exp_word = w; tag_w = "R4"; tag_s = "R5";
            if (exp_left > 0) exp_left = exp_left - 1;
        end
        exp_sync = (exp_left == 0);
        #1;
        checks += 2;
        if (word_out !== exp_word) begin
            errors++;
            $display("FAIL %s word_out actual=%h expected=%h", tag_w, word_out, exp_word);
        end
        if (sync_n !== exp_sync) begin
            errors++;
            $display("FAIL %s sync_n actual=%b expected=%b", tag_s, sync_n, exp_sync);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1'b1, 1'b0, 10'h155);
        step(1'b1, 1'b0, 10'h2AA);
        // R4: ordinary words, near-miss tag values
        step(1'b0, 1'b0, 10'h123);
        step(1'b0, 1'b0, 10'h0FF);
        step(1'b0, 1'b0, 10'h3FB);
        step(1'b0, 1'b0, 10'h004);
        // R2 / R3 / R5: sync sequence 3FF 000 000 then gap
        step(1'b0, 1'b0, 10'h3FC);
        step(1'b0, 1'b0, 10'h001);
        step(1'b0, 1'b0, 10'h002);
        step(1'b0, 1'b0, 10'h200);
        step(1'b0, 1'b0, 10'h201);
        step(1'b0, 1'b0, 10'h202);
        step(1'b0, 1'b0, 10'h203);
        step(1'b0, 1'b0, 10'h204);
        // R5: isolated match, full window and release
        step(1'b0, 1'b0, 10'h3FD);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 10'h180 + 10'(i));
        // R6: retrigger midway
        step(1'b0, 1'b0, 10'h003);
        step(1'b0, 1'b0, 10'h111);
        step(1'b0, 1'b0, 10'h3FE);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 10'h222);
        // R7: bypass with reserved codes and bypass mid-pulse
        step(1'b0, 1'b1, 10'h001);
        step(1'b0, 1'b1, 10'h3FC);
        step(1'b0, 1'b0, 10'h000);
        step(1'b0, 1'b1, 10'h3FE);
        step(1'b0, 1'b0, 10'h155);
        // R1: reset mid-pulse
        step(1'b0, 1'b0, 10'h3FF);
        step(1'b1, 1'b0, 10'h3FF);
        step(1'b0, 1'b0, 10'h0F0);
        // mixed stream
        for (int i = 0; i < 400; i++) begin
            int unsigned pick;
            logic [9:0]  w;
            pick = $urandom_range(0, 11);
            w = 10'($urandom);
            if (pick <= 1) w[9:2] = 8'h00;
            else if (pick <= 3) w[9:2] = 8'hFF;
            step(i == 200, pick == 11, w);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule